// File: doc/BRIEF.md
# Dual-Bank Serial Register Port

This block is a serial slave that lets a host reach two register banks through a single frame layout. One bank holds seven 16-bit registers that stand in for nonvolatile trim storage. The other bank holds 10-bit control and data registers. All storage is plain flip-flops. The serial clock, frame enable and data input are brought into the system clock domain by a synchronizer, and all frame logic runs on the system clock.

The host raises the enable line and then clocks in the frame, most significant bit first. A frame has four fields:
- a write flag;
- a bank flag;
- an address, whose width depends on the bank;
- a data field, whose width also depends on the bank.

Once the last address bit has arrived, the block shifts the addressed register's present value out on the data output during the data field. This happens in read frames and in write frames. A write is applied only when the enable line falls, and only if every condition holds:
- the frame had exactly the right number of bits for its bank;
- the address names a writable register;
- the bank is not locked.

Top module: `dual_bank_serial_port`

## Requirements
- R1: After reset, every register reads 0 and `ser_dout` is 0.
- R2: Frame bit order is: write flag (1 = write with readback, 0 = read only), bank flag (1 = 16-bit bank with a 3-bit address, 0 = 10-bit bank with a 5-bit address), address MSB first, then data MSB first. A write frame of exactly 21 bits (16-bit bank) or 17 bits (10-bit bank) is committed when the enable falls, and a later frame reads the new value back.
- R3: In every frame, `ser_dout` carries the addressed register's pre-frame value, MSB first, one bit per data-field bit. The host samples each bit before that data bit's rising serial clock edge. This also holds in write frames, where the old value is shown.
- R4: A frame with write flag 0 never changes any register, whatever its data bits are.
- R5: A write frame that is one or more bits too short, or too long, for its bank is discarded.
- R6: Address 7 of the 16-bit bank reads 0, and a write to it changes no register.
- R7: Addresses 15 to 31 of the 10-bit bank read 0, and writes to them are discarded.
- R8: Address 13 of the 10-bit bank reads `lin_result[9:0]`, and address 14 reads `lin_result[11:10]` zero-extended. Writes to either address have no effect.
- R9: Address 12 of the 10-bit bank stores only data bits 1:0. Its upper bits read 0.
- R10: When bit 15 of 16-bit-bank register 1 is 1, all writes to the 16-bit bank are rejected, including writes to register 1 itself. Writes to the 10-bit bank still take effect.
- R11: `ser_dout` is 0 while the enable is low and during the header and address bits. Serial clock edges seen while the enable is low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_en | input | 1 | Frame enable; high for the length of a frame |
| ser_din | input | 1 | Serial data from the host |
| lin_result | input | 12 | Value shown by the two read-only registers |
| ser_dout | output | 1 | Serial readback data; changes after falling serial clock edges |

## Verification
Two functions meet in one frame: the readback of a register and the commit of a write to that same register. The bench sends write frames to an address it has just written, often back to back. It judges the in-frame readback against the value held before the frame, and the following frame against the newly committed value. The lock bit brings a second overlap: the frame that sets the lock is committed, and every later write to the 16-bit bank is judged rejected.

// File: rtl/dbsp_pkg.sv
package dbsp_pkg;
  typedef enum logic {
    BANK_CTL = 1'b0,
    BANK_NV  = 1'b1
  } bank_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dbsp_sync.sv
module dbsp_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  for (genvar g = 0; g < STAGES; g++) begin : stg
    logic [W-1:0] s;
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) s <= '0;
        else     s <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) s <= '0;
        else     s <= stg[g-1].s;
      end
    end
  end

  assign q = stg[STAGES-1].s;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= q;
  end

  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/dbsp_frame.sv
module dbsp_frame
  import dbsp_pkg::*;
#(
  parameter int NV_AW  = 3,
  parameter int CTL_AW = 5,
  parameter int NV_DW  = 16,
  parameter int CTL_DW = 10
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    en_q,
  input  logic                                    en_rise,
  input  logic                                    en_fall,
  input  logic                                    sck_rise,
  input  logic                                    sck_fall,
  input  logic                                    din_q,
  input  logic [max2(NV_DW, CTL_DW)-1:0]          rd_data,
  input  logic                                    rd_valid,
  output logic                                    addr_done,
  output logic                                    bank,
  output logic [max2(NV_AW, CTL_AW)-1:0]          addr,
  output logic                                    cmt,
  output logic [max2(NV_DW, CTL_DW)-1:0]          cmt_data,
  output logic                                    sdo
);
  localparam int AWM    = max2(NV_AW, CTL_AW);
  localparam int DWM    = max2(NV_DW, CTL_DW);
  localparam int LEN_NV = 2 + NV_AW + NV_DW;
  localparam int LEN_CT = 2 + CTL_AW + CTL_DW;
  localparam int LENM   = max2(LEN_NV, LEN_CT);
  localparam int CW     = $clog2(LENM + 2);

  logic [CW-1:0]   cnt, cnt_inc;
  logic [LENM-1:0] sr, sr_nx;
  logic            wr_q, bank_q, bank_cur, hit_addr, len_ok, armed;
  logic [DWM-1:0]  tx;

  assign sr_nx    = {sr[LENM-2:0], din_q};
  assign cnt_inc  = (cnt == CW'(LENM + 1)) ? cnt : cnt + 1'b1;
  assign bank_cur = (cnt == CW'(1)) ? din_q : bank_q;
  assign hit_addr = (cnt_inc == (bank_cur ? CW'(2 + NV_AW) : CW'(2 + CTL_AW)));
  assign len_ok   = (cnt == (bank_q ? CW'(LEN_NV) : CW'(LEN_CT)));
  assign cmt_data = bank_q ? DWM'(sr[NV_DW-1:0]) : DWM'(sr[CTL_DW-1:0]);
  assign bank     = bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; sr <= '0; wr_q <= 1'b0; bank_q <= 1'b0; addr <= '0;
      addr_done <= 1'b0; cmt <= 1'b0; armed <= 1'b0; tx <= '0; sdo <= 1'b0;
    end else begin
      addr_done <= 1'b0;
      cmt       <= 1'b0;
      if (en_rise) begin
        cnt <= '0; sr <= '0; armed <= 1'b0; tx <= '0;
      end else if (en_q && sck_rise) begin
        sr  <= sr_nx;
        cnt <= cnt_inc;
        if (cnt == CW'(0)) wr_q   <= din_q;
        if (cnt == CW'(1)) bank_q <= din_q;
        if (cnt != CW'(0) && hit_addr) begin
          addr      <= bank_cur ? AWM'(sr_nx[NV_AW-1:0]) : AWM'(sr_nx[CTL_AW-1:0]);
          addr_done <= 1'b1;
        end
      end
      if (rd_valid) begin
        tx    <= rd_data;
        armed <= 1'b1;
      end else if (en_q && sck_fall && armed) begin
        tx <= {tx[DWM-2:0], 1'b0};
      end
      if (!en_q)                        sdo <= 1'b0;
      else if (sck_fall && armed && !rd_valid) sdo <= tx[DWM-1];
      if (en_fall) cmt <= wr_q && len_ok;
    end
  end

  p_dout_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !sdo);

  p_commit_end_r5: assert property (@(posedge clk) disable iff (rst)
    cmt |-> !en_q);
endmodule

// File: rtl/dbsp_regfile.sv
module dbsp_regfile
  import dbsp_pkg::*;
#(
  parameter int NV_AW    = 3,
  parameter int CTL_AW   = 5,
  parameter int NV_DW    = 16,
  parameter int CTL_DW   = 10,
  parameter int CTL_RW   = 13,
  parameter int LIN_W    = 12,
  parameter int LOCK_REG = 1,
  parameter int LOCK_BIT = 15
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            rd_req,
  input  logic                            bank,
  input  logic [max2(NV_AW, CTL_AW)-1:0]  addr,
  input  logic                            we,
  input  logic [max2(NV_DW, CTL_DW)-1:0]  wdata,
  input  logic [LIN_W-1:0]                lin_result,
  output logic [max2(NV_DW, CTL_DW)-1:0]  rd_data,
  output logic                            rd_valid
);
  localparam int AWM  = max2(NV_AW, CTL_AW);
  localparam int DWM  = max2(NV_DW, CTL_DW);
  localparam int NV_N = (1 << NV_AW) - 1;
  localparam int HI_W = LIN_W - CTL_DW;
  localparam logic [CTL_DW-1:0] HI_MASK = CTL_DW'((1 << HI_W) - 1);

  logic [NV_N-1:0][NV_DW-1:0]    nv_q;
  logic [CTL_RW-1:0][CTL_DW-1:0] ct_q;
  logic [DWM-1:0]                rd_nx;
  logic                          lock;

  assign lock = nv_q[LOCK_REG][LOCK_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      nv_q <= '0;
    end else if (we && bank == BANK_NV && !lock) begin
      for (int i = 0; i < NV_N; i++)
        if (addr == AWM'(i)) nv_q[i] <= wdata[NV_DW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ct_q <= '0;
    end else if (we && bank == BANK_CTL) begin
      for (int i = 0; i < CTL_RW; i++)
        if (addr == AWM'(i))
          ct_q[i] <= (i == CTL_RW - 1) ? (wdata[CTL_DW-1:0] & HI_MASK) : wdata[CTL_DW-1:0];
    end
  end

  always_comb begin
    rd_nx = '0;
    if (bank == BANK_NV) begin
      for (int i = 0; i < NV_N; i++)
        if (addr == AWM'(i)) rd_nx = DWM'(nv_q[i]) << (DWM - NV_DW);
    end else begin
      for (int i = 0; i < CTL_RW; i++)
        if (addr == AWM'(i)) rd_nx = DWM'(ct_q[i]) << (DWM - CTL_DW);
      if (addr == AWM'(CTL_RW))
        rd_nx = DWM'(lin_result[CTL_DW-1:0]) << (DWM - CTL_DW);
      if (addr == AWM'(CTL_RW + 1))
        rd_nx = DWM'(lin_result[LIN_W-1:CTL_DW]) << (DWM - CTL_DW);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_nx;
    end
  end

  p_locked_hold_r10: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(nv_q));

  p_bad_nv_write_r6: assert property (@(posedge clk) disable iff (rst)
    (we && bank && addr >= AWM'(NV_N)) |=> $stable(nv_q));

  p_bad_ctl_write_r7: assert property (@(posedge clk) disable iff (rst)
    (we && !bank && addr >= AWM'(CTL_RW)) |=> $stable(ct_q));

  p_bad_nv_read_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_req && bank && addr >= AWM'(NV_N)) |=> rd_data == '0);
endmodule

// File: rtl/dual_bank_serial_port.sv
module dual_bank_serial_port
  import dbsp_pkg::*;
#(
  parameter int NV_AW       = 3,
  parameter int CTL_AW      = 5,
  parameter int NV_DW       = 16,
  parameter int CTL_DW      = 10,
  parameter int CTL_RW      = 13,
  parameter int LIN_W       = 12,
  parameter int LOCK_REG    = 1,
  parameter int LOCK_BIT    = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             ser_en,
  input  logic             ser_din,
  input  logic [LIN_W-1:0] lin_result,
  output logic             ser_dout
);
  localparam int AWM = max2(NV_AW, CTL_AW);
  localparam int DWM = max2(NV_DW, CTL_DW);

  logic [2:0]     s_q, s_rise, s_fall;
  logic           addr_done, bank, cmt, rd_valid;
  logic [AWM-1:0] addr;
  logic [DWM-1:0] cmt_data, rd_data;

  dbsp_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk(clk), .rst(rst), .din({ser_clk, ser_en, ser_din}),
    .q(s_q), .rise(s_rise), .fall(s_fall)
  );

  dbsp_frame #(.NV_AW(NV_AW), .CTL_AW(CTL_AW), .NV_DW(NV_DW), .CTL_DW(CTL_DW)) u_frame (
    .clk(clk), .rst(rst),
    .en_q(s_q[1]), .en_rise(s_rise[1]), .en_fall(s_fall[1]),
    .sck_rise(s_rise[2]), .sck_fall(s_fall[2]), .din_q(s_q[0]),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .addr_done(addr_done), .bank(bank), .addr(addr),
    .cmt(cmt), .cmt_data(cmt_data), .sdo(ser_dout)
  );

  dbsp_regfile #(.NV_AW(NV_AW), .CTL_AW(CTL_AW), .NV_DW(NV_DW), .CTL_DW(CTL_DW),
                 .CTL_RW(CTL_RW), .LIN_W(LIN_W), .LOCK_REG(LOCK_REG),
                 .LOCK_BIT(LOCK_BIT)) u_regs (
    .clk(clk), .rst(rst), .rd_req(addr_done), .bank(bank), .addr(addr),
    .we(cmt), .wdata(cmt_data), .lin_result(lin_result),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: tb/test_dual_bank_serial_port.sv
module test_dual_bank_serial_port;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_en = 1'b0, ser_din = 1'b0;
  logic [11:0] lin_result = 12'h000;
  logic ser_dout;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [15:0] nv_m [8];
  logic [9:0]  ct_m [32];

  always #2 clk = ~clk;

  dual_bank_serial_port i_dual_bank_serial_port (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_en(ser_en),
    .ser_din(ser_din), .lin_result(lin_result), .ser_dout(ser_dout)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic bank, input int addr);
    if (bank) return (addr < 7) ? nv_m[addr] : 16'h0;
    if (addr < 13) return {6'b0, ct_m[addr]};
    if (addr == 13) return {6'b0, lin_result[9:0]};
    if (addr == 14) return {14'b0, lin_result[11:10]};
    return 16'h0;
  endfunction

  function automatic void model_write(input logic bank, input int addr, input logic [15:0] d);
    if (bank) begin
      if (addr < 7 && !nv_m[1][15]) nv_m[addr] = d;
    end else begin
      if (addr < 12) ct_m[addr] = d[9:0];
      else if (addr == 12) ct_m[addr] = {8'b0, d[1:0]};
    end
  endfunction

  task automatic run_frame(input logic wr, input logic bank, input int addr,
                           input logic [15:0] data, input int adj, input string tag);
    int aw, dw, len, ncap;
    logic [15:0] cap, exp;
    aw = bank ? 3 : 5;
    dw = bank ? 16 : 10;
    len = 2 + aw + dw + adj;
    exp = exp_rd(bank, addr);
    cap = '0;
    ncap = 0;
    ser_en = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      if (i == 0) ser_din = wr;
      else if (i == 1) ser_din = bank;
      else if (i < 2 + aw) ser_din = addr[aw - 1 - (i - 2)];
      else if (i < 2 + aw + dw) ser_din = data[dw - 1 - (i - 2 - aw)];
      else ser_din = 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < 2 + aw) chk({15'b0, ser_dout}, 16'h0, "R11 header dout");
      else if (ncap < dw) begin
        cap = {cap[14:0], ser_dout};
        ncap++;
      end
      ser_clk = 1'b1;
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    ser_en = 1'b0;
    repeat (3 * HALF) @(negedge clk);
    chk(cap, exp >> (dw - ncap), tag);
    if (wr && adj == 0) model_write(bank, addr, data);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic b, w;
    int a, adj, r;
    for (int i = 0; i < 8; i++) nv_m[i] = '0;
    for (int i = 0; i < 32; i++) ct_m[i] = '0;
    void'($urandom(32'd5150));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    chk({15'b0, ser_dout}, 16'h0, "R1 dout after reset");
    run_frame(0, 1, 0, 16'h0, 0, "R1 nv0 reset");
    run_frame(0, 1, 6, 16'h0, 0, "R1 nv6 reset");
    run_frame(0, 0, 0, 16'h0, 0, "R1 ctl0 reset");
    run_frame(0, 0, 12, 16'h0, 0, "R1 ctl12 reset");

    run_frame(1, 1, 3, 16'hA5C3, 0, "R3 old value in write frame");
    run_frame(0, 1, 3, 16'h0, 0, "R2 nv3 readback");
    run_frame(1, 0, 5, 16'h02AB, 0, "R3 ctl5 old value");
    run_frame(0, 0, 5, 16'h0, 0, "R2 ctl5 readback");
    run_frame(1, 1, 3, 16'h1234, 0, "R3 nv3 shows A5C3");
    run_frame(1, 1, 3, 16'h4321, 0, "R3 nv3 shows 1234");

    run_frame(0, 0, 5, 16'h03FF, 0, "R4 read with data");
    run_frame(0, 0, 5, 16'h0, 0, "R4 ctl5 unchanged");

    run_frame(1, 1, 3, 16'hFFFF, -1, "R5 short write");
    run_frame(0, 1, 3, 16'h0, 0, "R5 nv3 after short");
    run_frame(1, 0, 5, 16'h0155, 1, "R5 long write");
    run_frame(0, 0, 5, 16'h0, 0, "R5 ctl5 after long");

    run_frame(1, 1, 7, 16'hFFFF, 0, "R6 nv7 write");
    run_frame(0, 1, 7, 16'h0, 0, "R6 nv7 reads zero");
    run_frame(0, 1, 6, 16'h0, 0, "R6 nv6 untouched");

    run_frame(1, 0, 20, 16'h03FF, 0, "R7 ctl20 write");
    run_frame(0, 0, 20, 16'h0, 0, "R7 ctl20 reads zero");
    run_frame(0, 0, 15, 16'h0, 0, "R7 ctl15 reads zero");

    lin_result = 12'hABC;
    run_frame(0, 0, 13, 16'h0, 0, "R8 lin low");
    run_frame(0, 0, 14, 16'h0, 0, "R8 lin high");
    run_frame(1, 0, 13, 16'h0155, 0, "R8 write lin low");
    run_frame(1, 0, 14, 16'h03FF, 0, "R8 write lin high");
    run_frame(0, 0, 13, 16'h0, 0, "R8 lin low unchanged");

    run_frame(1, 0, 12, 16'h03FF, 0, "R9 narrow write");
    run_frame(0, 0, 12, 16'h0, 0, "R9 narrow readback");

    ser_din = 1'b1;
    for (int i = 0; i < 5; i++) begin
      ser_clk = 1'b1;
      repeat (HALF) @(negedge clk);
      chk({15'b0, ser_dout}, 16'h0, "R11 idle dout");
      ser_clk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    run_frame(0, 0, 5, 16'h0, 0, "R11 ctl5 after idle edges");

    for (int n = 0; n < 150; n++) begin
      w = 1'($urandom_range(0, 1));
      b = 1'($urandom_range(0, 1));
      a = b ? $urandom_range(0, 7) : $urandom_range(0, 31);
      d = 16'($urandom);
      if (b && a == 1) d[15] = 1'b0;
      r = $urandom_range(0, 9);
      adj = (r == 0) ? -1 : ((r == 1) ? 1 : 0);
      if ($urandom_range(0, 7) == 0) lin_result = 12'($urandom);
      run_frame(w, b, a, d, adj, "R3 random frame");
    end

    run_frame(1, 1, 1, 16'h8000, 0, "R10 set lock");
    run_frame(1, 1, 2, 16'h7777, 0, "R10 locked write");
    run_frame(0, 1, 2, 16'h0, 0, "R10 nv2 unchanged");
    run_frame(1, 1, 1, 16'h0000, 0, "R10 unlock attempt");
    run_frame(0, 1, 1, 16'h0, 0, "R10 lock stays");
    run_frame(1, 0, 7, 16'h0123, 0, "R10 ctl write while locked");
    run_frame(0, 0, 7, 16'h0, 0, "R10 ctl7 readback");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule